// File: doc/BRIEF.md
# Two-Stage SPI Baud Divider

This block derives the serial-clock timing of an SPI master from its module clock. A 6-bit rate value picks the divisor as the product of two stages. A linear prescale stage divides by 1 to 8. A power-of-two stage divides by 2 to 256. Together they reach every divisor of the form (P+1)·2^(S+1), from 2 up to 2048. Because the prescale stage is linear, rates that are not a power of two, such as divide by 6 or by 10, are available.

While the run enable is high, the block emits a one-cycle tick at every half-period boundary of the serial clock, so a shift engine can toggle its clock line on each tick. While the enable is low, the block takes in the rate value and holds its counters at zero. It also presents the active divisor for observation.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset, `divisor_out` reads 2 and `half_tick` is low.
- R2: The rate value is split into two fields. The preselect field P is `rate_cfg[5:3]` and the select field S is `rate_cfg[2:0]`. The active divisor is (P+1)·2^(S+1). Examples: P=0,S=0 gives 2; P=0,S=1 gives 4; P=0,S=2 gives 8; P=1,S=0 gives 4; P=7,S=7 gives 2048.
- R3: Divisors that are not a power of two are produced. P=2,S=0 gives 6, P=4,S=0 gives 10 and P=2,S=1 gives 12.
- R4: `half_tick` stays low for as long as `run` is low.
- R5: Let H = divisor/2. With `run` held high, counting the first cycle in which `run` is high as cycle 1, `half_tick` is high exactly in cycles H, 2H, 3H and so on.
- R6: A change of `rate_cfg` while `run` is high has no effect. Both `divisor_out` and the tick spacing keep the value that was taken in before `run` rose.
- R7: Dropping `run` for a single cycle clears the divider state. The next run then restarts the tick count from cycle 1.
- R8: When H > 1, `half_tick` is high for one cycle only, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_cfg | input | 6 | Rate value: preselect field in [5:3], select field in [2:0] |
| run | input | 1 | Run enable; the rate value is taken in while it is low |
| half_tick | output | 1 | One-cycle pulse at each serial-clock half-period boundary |
| divisor_out | output | 12 | Active divisor of the module clock |

## Verification
`divisor_out` is due one clock after `rate_cfg` is applied with `run` low. The bench drives the value on a falling edge and reads the output one nanosecond after the following falling edge. `half_tick` is a combinational result of the counters and `run`. The bench therefore samples it one nanosecond after each falling edge, beginning with the falling edge at which `run` is raised, and numbers those samples from 1. This numbering lets the expected tick positions H and 2H be compared directly with the requirement. The checks for the ignored rate change and the one-cycle run drop use the same sample points, so every expected value lines up with a known count of clock edges.

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int PRE_W = 3,
  parameter int SEL_W = 3,
  localparam int CFG_W = PRE_W + SEL_W,
  localparam int POW_W = (1 << SEL_W) - 1,
  localparam int DIV_W = PRE_W + (1 << SEL_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] rate_cfg,
  input  logic             run,
  output logic             half_tick,
  output logic [DIV_W-1:0] divisor_out
);

  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W:0]   pow_span;
  logic             pre_wrap;
  logic             pow_wrap;

  assign pow_span = {{POW_W{1'b0}}, 1'b1} << sel_q;
  assign pre_wrap = (pre_cnt == pre_q);
  assign pow_wrap = ({1'b0, pow_cnt} == (pow_span - 1'b1));
  assign half_tick = run & pre_wrap & pow_wrap;
  assign divisor_out = (({{(DIV_W-PRE_W){1'b0}}, pre_q} + DIV_W'(1)) << sel_q) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sel_q   <= '0;
      pre_cnt <= '0;
      pow_cnt <= '0;
    end else if (!run) begin
      pre_q   <= rate_cfg[CFG_W-1:SEL_W];
      sel_q   <= rate_cfg[SEL_W-1:0];
      pre_cnt <= '0;
      pow_cnt <= '0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap)
        pow_cnt <= pow_wrap ? '0 : pow_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             half_tick,
  input logic [DIV_W-1:0] divisor_out
);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !half_tick);

  p_hold_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(divisor_out));

  p_div_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor_out[0] == 1'b0) && (divisor_out >= DIV_W'(2)));

  p_single_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick && (divisor_out > DIV_W'(2)) |=> !half_tick);

  p_no_early_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) && (divisor_out > DIV_W'(2)) |-> !half_tick);

endmodule

bind spi_rate_gen spi_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .half_tick(half_tick), .divisor_out(divisor_out));

// File: tb/spi_rate_gen_test.sv
module spi_rate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [17:0] VEC [NVEC] = '{
    {6'o00, 12'd2},   {6'o01, 12'd4},  {6'o02, 12'd8},  {6'o10, 12'd4},
    {6'o20, 12'd6},   {6'o40, 12'd10}, {6'o21, 12'd12}, {6'o70, 12'd16},
    {6'o07, 12'd256}, {6'o77, 12'd2048}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rate_cfg = '0;
  logic        run = 1'b0;
  logic        half_tick;
  logic [11:0] divisor_out;
  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  spi_rate_gen uut (.clk(clk), .rst_n(rst_n), .rate_cfg(rate_cfg), .run(run),
                    .half_tick(half_tick), .divisor_out(divisor_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [5:0] cfg);
    @(negedge clk); run = 1'b0; rate_cfg = cfg;
    @(negedge clk); #1;
  endtask

  task automatic measure(input int h, input bit chg, input logic [5:0] newcfg,
                         output int first, output int second, output int cnt);
    first = 0; second = 0; cnt = 0;
    @(negedge clk); run = 1'b1;
    for (int k = 1; k <= 2*h; k++) begin
      if (k > 1) @(negedge clk);
      if (chg && k == 2) rate_cfg = newcfg;
      #1;
      if (half_tick) begin
        cnt++;
        if (first == 0) first = k; else if (second == 0) second = k;
      end
    end
    @(negedge clk); run = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    int f, s, c, n;
    #(CLK_PERIOD*2 + 3);
    check("R1 divisor at reset", divisor_out, 2);
    check("R1 tick at reset", half_tick, 0);
    rst_n = 1'b1;

    configure(6'o00);
    n = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); #1; n += half_tick; end
    check("R4 ticks while idle", n, 0);

    for (int i = 0; i < NVEC; i++) begin
      int h;
      h = int'(VEC[i][11:0]) / 2;
      configure(VEC[i][17:12]);
      check((i==4 || i==5 || i==6) ? "R3 divisor" : "R2 divisor",
            divisor_out, int'(VEC[i][11:0]));
      measure(h, 1'b0, 6'o00, f, s, c);
      check("R5 first tick", f, h);
      check("R5 second tick", s, 2*h);
      check("R8 tick count in window", c, 2);
    end

    configure(6'o20);
    measure(3, 1'b1, 6'o77, f, s, c);
    check("R6 first tick after change", f, 3);
    check("R6 second tick after change", s, 6);
    @(negedge clk); #1;
    check("R6 divisor after change", divisor_out, 2048);
    configure(6'o20);
    check("R6 divisor retaken when idle", divisor_out, 6);

    configure(6'o30);
    @(negedge clk); run = 1'b1;
    n = 0;
    for (int k = 0; k < 2; k++) begin #1; n += half_tick; @(negedge clk); end
    run = 1'b0;
    check("R7 no tick in partial run", n, 0);
    measure(4, 1'b0, 6'o30, f, s, c);
    check("R7 restart first tick", f, 4);
    check("R7 restart second tick", s, 8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule